// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a single configuration-request source and the configuration register files of every device function in a small tree of buses. Each request names a bus number, a device/function byte, a register offset and an access width of one, two or four bytes. The router finds the bus segment that the bus number belongs to. Bus 0 is always the root. Every other number is matched against the secondary bus number that software has written into each bridge. The router then checks that the addressed device slot is occupied and forwards the access, with byte lanes aligned, to the register files of the chosen segment.

Reads that reach no target complete with an all-ones value of the access width. Writes that reach no target vanish without any downstream activity. The router keeps its own copy of every bridge's secondary bus number. It builds that copy by watching the configuration writes it forwards to the bridges, so the routing follows enumeration software with no separate programming path.

The tree shape is fixed by parameters: which segment each bridge sits on and at which device/function. Bridge k forwards to segment k+1. Downstream register files return read data combinationally in the cycle where the forwarded access is presented.

Top module: `cfgr_router`

## Requirements
- R1: The request address carries the bus number in bits 23:16, the device/function byte in bits 15:8 (device in 7:3, function in 2:0) and the register offset in bits 7:0. A forwarded access presents that device/function byte and the dword index offset[7:2] unchanged.
- R2: Bus number 0 always selects the root segment 0. A request whose device slot on the selected segment is not marked present is a miss. Presence is per device: bit seg*32+device of `dev_present`.
- R3: A read miss returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for width code 0 (byte), 1 (word) and 2 (dword).
- R4: A write miss produces no downstream access, and no forwarded access happens without a hit.
- R5: Byte enables are the width mask (0001, 0011, 1111) shifted left by offset[1:0]. Write data is masked to the width and shifted by 8*offset[1:0]. Read data is shifted down by the same amount and masked to the width.
- R6: A word at an odd offset, a dword at an offset that is not a multiple of 4, and width code 3 are all treated as misses. A width-code-3 read returns 0xFFFFFFFF.
- R7: Every bridge's secondary bus number is 0 after reset. A secondary number of 0 matches no request, and a number changes only through the snooped writes of R8 and R9.
- R8: A forwarded byte write to offset 0x19 of a bridge loads that bridge's secondary bus number from data bits 7:0.
- R9: A forwarded word or dword write to offset 0x18 of a bridge loads the number from data bits 15:8. A byte write to 0x18 leaves it unchanged.
- R10: `req_ready` is always high. A forwarded access appears on the downstream port in the cycle after acceptance. Each accepted read produces exactly one `rsp_valid` pulse two cycles after acceptance, and writes produce none.
- R11: When several bridges hold the same nonzero number, the lowest-numbered bridge wins the route.
- R12: A bridge's own slot counts as present on its parent segment whatever `dev_present` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Width code: 0 byte, 1 word, 2 dword |
| req_addr | input | 24 | Bus, device/function, offset |
| req_wdata | input | 32 | Write data, right-aligned |
| dev_present | input | N_SEG*32 | Occupied device slots per segment |
| dn_valid | output | 1 | Forwarded access strobe |
| dn_write | output | 1 | Forwarded access is a write |
| dn_seg | output | SEG_W | Target segment |
| dn_devfn | output | 8 | Target device/function |
| dn_reg | output | 6 | Dword index within the function |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rdata | input | 32 | Dword read data from the target |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response, right-aligned |

## Verification
The hardest situation to reach is the one where two bridges hold the same bus number, and the one where a bridge's number has been reprogrammed back to zero. Both need a sequence of snooped writes that go through the router itself, first to reach the second bridge and then to reshape the tree. The stimulus programs bridge 0, uses that route to reach bridge 1 and program it, and then makes bridge 1 copy bridge 0's number to test priority. It clears bridge 0 to show that the route falls through to bridge 1. A byte write at the low byte offset is placed in this chain to show that it is ignored.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } acc_size_e;

  localparam int DEV_SLOTS = 32;
  localparam logic [7:0] SEC_LO_OFS = 8'h19;
  localparam logic [7:0] SEC_HI_OFS = 8'h18;

  // All-ones value of the access width (miss data and read mask).
  function automatic logic [31:0] size_ones(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Lane mask before shifting by the byte offset.
  function automatic logic [3:0] size_lanes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'b0001;
      SZ_WORD: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Natural alignment test; width code 3 is never legal.
  function automatic logic size_aligned(input logic [1:0] sz, input logic [1:0] ofs);
    case (sz)
      SZ_BYTE:  return 1'b1;
      SZ_WORD:  return ~ofs[0];
      SZ_DWORD: return ofs == 2'b00;
      default:  return 1'b0;
    endcase
  endfunction

  // A programmed bridge number claims a bus only when nonzero.
  function automatic logic sec_claims(input logic [7:0] sec, input logic [7:0] bus);
    return (sec != 8'h00) && (sec == bus);
  endfunction

endpackage

// File: rtl/cfgr_bus_table.sv
module cfgr_bus_table
  import cfgr_pkg::*;
#(
  parameter int N_BRIDGE = 2,
  parameter int SEG_W = 2,
  parameter logic [N_BRIDGE*8-1:0] BR_PARENT = 16'h01_00,
  parameter logic [N_BRIDGE*8-1:0] BR_DEVFN  = 16'h10_08
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [SEG_W-1:0]      wr_seg,
  input  logic [7:0]            wr_devfn,
  input  logic [7:0]            wr_off,
  input  logic [1:0]            wr_size,
  input  logic [31:0]           wr_data,
  output logic [N_BRIDGE*8-1:0] sec_num
);

  logic [N_BRIDGE-1:0] upd_lo;
  logic [N_BRIDGE-1:0] upd_hi;
  logic [7:0]          sec_q [N_BRIDGE];

  for (genvar k = 0; k < N_BRIDGE; k++) begin : g_br
    logic at_bridge;
    assign at_bridge = wr_fire && (8'(wr_seg) == BR_PARENT[k*8 +: 8])
                       && (wr_devfn == BR_DEVFN[k*8 +: 8]);
    assign upd_lo[k] = at_bridge && (wr_off == SEC_LO_OFS) && (wr_size == SZ_BYTE);
    assign upd_hi[k] = at_bridge && (wr_off == SEC_HI_OFS)
                       && ((wr_size == SZ_WORD) || (wr_size == SZ_DWORD));

    always_ff @(posedge clk) begin
      if (!rst_n)          sec_q[k] <= 8'h00;
      else if (upd_lo[k])  sec_q[k] <= wr_data[7:0];
      else if (upd_hi[k])  sec_q[k] <= wr_data[15:8];
    end

    assign sec_num[k*8 +: 8] = sec_q[k];

    p_lo_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_lo[k] |=> sec_q[k] == $past(wr_data[7:0]));
    p_hi_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hi[k] |=> sec_q[k] == $past(wr_data[15:8]));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_lo[k] || upd_hi[k]) |=> $stable(sec_q[k]));
  end

endmodule

// File: rtl/cfgr_target_decode.sv
module cfgr_target_decode
  import cfgr_pkg::*;
#(
  parameter int N_BRIDGE = 2,
  parameter int N_SEG = 3,
  parameter int SEG_W = 2,
  parameter logic [N_BRIDGE*8-1:0] BR_PARENT = 16'h01_00,
  parameter logic [N_BRIDGE*8-1:0] BR_DEVFN  = 16'h10_08
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 bus_num,
  input  logic [7:0]                 devfn,
  input  logic [N_BRIDGE*8-1:0]      sec_num,
  input  logic [N_SEG*DEV_SLOTS-1:0] dev_present,
  output logic                       tgt_hit,
  output logic [SEG_W-1:0]           tgt_seg
);

  logic [N_BRIDGE-1:0] br_match;
  logic [SEG_W-1:0]    br_seg;
  logic                root_sel;
  logic                bus_known;
  logic                slot_listed;
  logic                slot_bridge;
  logic [4:0]          dev;

  assign dev = devfn[7:3];

  for (genvar k = 0; k < N_BRIDGE; k++) begin : g_cmp
    assign br_match[k] = sec_claims(sec_num[k*8 +: 8], bus_num);
  end

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    br_seg = '0;
    for (int k = N_BRIDGE - 1; k >= 0; k--) begin
      if (br_match[k]) br_seg = SEG_W'(k + 1);
    end
  end

  assign root_sel  = (bus_num == 8'h00);
  assign bus_known = root_sel || (|br_match);
  assign tgt_seg   = root_sel ? '0 : br_seg;

  always_comb begin
    slot_bridge = 1'b0;
    for (int k = 0; k < N_BRIDGE; k++) begin
      if ((BR_PARENT[k*8 +: 8] == 8'(tgt_seg)) && (BR_DEVFN[k*8+3 +: 5] == dev))
        slot_bridge = 1'b1;
    end
  end

  assign slot_listed = dev_present[int'(tgt_seg) * DEV_SLOTS + int'(dev)];
  assign tgt_hit     = bus_known && (slot_listed || slot_bridge);

  p_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
    root_sel |-> tgt_seg == '0);
  p_bridge_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_known && !root_sel) |-> sec_num[(int'(tgt_seg) - 1) * 8 +: 8] == bus_num);
  p_zero_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_seg != '0) |-> bus_num != 8'h00);

endmodule

// File: rtl/cfgr_lane_map.sv
module cfgr_lane_map
  import cfgr_pkg::*;
(
  input  logic [1:0]  wr_size,
  input  logic [1:0]  wr_ofs,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_size,
  input  logic [1:0]  rd_ofs,
  input  logic [31:0] rd_dword,
  output logic [3:0]  lane_be,
  output logic [31:0] lane_wdata,
  output logic [31:0] lane_rdata
);

  assign lane_be    = size_lanes(wr_size) << wr_ofs;
  assign lane_wdata = (wr_data & size_ones(wr_size)) << {wr_ofs, 3'b000};
  assign lane_rdata = (rd_dword >> {rd_ofs, 3'b000}) & size_ones(rd_size);

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
  import cfgr_pkg::*;
#(
  parameter int N_BRIDGE = 2,
  parameter logic [N_BRIDGE*8-1:0] BR_PARENT = 16'h01_00,
  parameter logic [N_BRIDGE*8-1:0] BR_DEVFN  = 16'h10_08,
  localparam int N_SEG = N_BRIDGE + 1,
  localparam int SEG_W = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [1:0]                 req_size,
  input  logic [23:0]                req_addr,
  input  logic [31:0]                req_wdata,
  input  logic [N_SEG*DEV_SLOTS-1:0] dev_present,
  output logic                       dn_valid,
  output logic                       dn_write,
  output logic [SEG_W-1:0]           dn_seg,
  output logic [7:0]                 dn_devfn,
  output logic [5:0]                 dn_reg,
  output logic [3:0]                 dn_be,
  output logic [31:0]                dn_wdata,
  input  logic [31:0]                dn_rdata,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_data
);

  logic [7:0]            a_bus, a_devfn, a_off;
  logic [N_BRIDGE*8-1:0] sec_num;
  logic                  tgt_hit;
  logic [SEG_W-1:0]      tgt_seg;
  logic                  acc_ok;
  logic                  fwd_go;
  logic                  wr_snoop;
  logic [3:0]            lane_be;
  logic [31:0]           lane_wdata, lane_rdata;
  logic                  rd_q, miss_q;
  logic [1:0]            sz_q, ofs_q;

  assign req_ready = 1'b1;
  assign a_bus     = req_addr[23:16];
  assign a_devfn   = req_addr[15:8];
  assign a_off     = req_addr[7:0];
  assign acc_ok    = size_aligned(req_size, a_off[1:0]);
  assign fwd_go    = req_valid && tgt_hit && acc_ok;
  assign wr_snoop  = fwd_go && req_write;

  cfgr_target_decode #(
    .N_BRIDGE(N_BRIDGE), .N_SEG(N_SEG), .SEG_W(SEG_W),
    .BR_PARENT(BR_PARENT), .BR_DEVFN(BR_DEVFN)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_num(a_bus), .devfn(a_devfn),
    .sec_num(sec_num), .dev_present(dev_present),
    .tgt_hit(tgt_hit), .tgt_seg(tgt_seg)
  );

  cfgr_bus_table #(
    .N_BRIDGE(N_BRIDGE), .SEG_W(SEG_W),
    .BR_PARENT(BR_PARENT), .BR_DEVFN(BR_DEVFN)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_snoop), .wr_seg(tgt_seg),
    .wr_devfn(a_devfn), .wr_off(a_off), .wr_size(req_size),
    .wr_data(req_wdata), .sec_num(sec_num)
  );

  cfgr_lane_map u_lane (
    .wr_size(req_size), .wr_ofs(a_off[1:0]), .wr_data(req_wdata),
    .rd_size(sz_q), .rd_ofs(ofs_q), .rd_dword(dn_rdata),
    .lane_be(lane_be), .lane_wdata(lane_wdata), .lane_rdata(lane_rdata)
  );

  // Stage 1: forwarded access toward the register files.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_seg   <= '0;
      dn_devfn <= '0;
      dn_reg   <= '0;
      dn_be    <= '0;
      dn_wdata <= '0;
      rd_q     <= 1'b0;
      miss_q   <= 1'b0;
      sz_q     <= SZ_BYTE;
      ofs_q    <= '0;
    end else begin
      dn_valid <= fwd_go;
      rd_q     <= req_valid && !req_write;
      miss_q   <= !fwd_go;
      if (req_valid) begin
        dn_write <= req_write;
        dn_seg   <= tgt_seg;
        dn_devfn <= a_devfn;
        dn_reg   <= a_off[7:2];
        dn_be    <= lane_be;
        dn_wdata <= lane_wdata;
        sz_q     <= req_size;
        ofs_q    <= a_off[1:0];
      end
    end
  end

  // Stage 2: read response.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_q;
      if (rd_q) rsp_data <= miss_q ? size_ones(sz_q) : lane_rdata;
    end
  end

  p_fwd_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> $past(req_valid && tgt_hit && acc_ok));
  p_misalign_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> !dn_valid);
  p_read_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> ##2 rsp_valid);
  p_rsp_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write, 2));
  p_miss_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(dn_valid)) |-> rsp_data == size_ones($past(req_size, 2)));
  p_lane_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ($countones(dn_be) == 1 || $countones(dn_be) == 2 || $countones(dn_be) == 4));

endmodule

// File: tb/sim_cfgr_router.sv
module sim_cfgr_router;

  localparam int N_SEG = 3;
  localparam int SEG_W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [N_SEG*32-1:0] dev_present;
  logic        dn_valid, dn_write;
  logic [SEG_W-1:0] dn_seg;
  logic [7:0]  dn_devfn;
  logic [5:0]  dn_reg;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata, dn_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        c_dnv, c_rsp_early, c_rspv;
  logic [3:0]  c_be;
  logic [31:0] c_wd, c_rspd;
  logic [SEG_W-1:0] c_seg;
  logic [7:0]  c_devfn;
  logic [5:0]  c_reg;

  always #5 clk = ~clk;

  // Occupied slots: seg0 dev0,dev3; seg1 dev5; seg2 dev7. Bridge slots left clear.
  assign dev_present = (96'd1 << 0) | (96'd1 << 3) | (96'd1 << 37) | (96'd1 << 71);

  // Register-file model: each dword identifies where it was read from.
  assign dn_rdata = {dn_devfn, dn_seg, dn_reg, 8'h5A, 8'hC3};

  cfgr_router u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .dev_present(dev_present), .dn_valid(dn_valid),
    .dn_write(dn_write), .dn_seg(dn_seg), .dn_devfn(dn_devfn), .dn_reg(dn_reg),
    .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [1:0] sz, input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    c_dnv = dn_valid; c_be = dn_be; c_wd = dn_wdata; c_seg = dn_seg;
    c_devfn = dn_devfn; c_reg = dn_reg; c_rsp_early = rsp_valid;
    @(negedge clk);
    c_rspv = rsp_valid; c_rspd = rsp_data;
  endtask

  task automatic rd_expect(input logic [1:0] sz, input logic [23:0] a, input logic [31:0] exp, input string tag);
    issue(1'b0, sz, a, 32'h0);
    chk(c_rspv === 1'b1, tag, {31'b0, c_rspv}, 32'h1);
    chk(c_rspd === exp, tag, c_rspd, exp);
  endtask

  // {write, size, addr, wdata, exp_dn, exp_be, exp_value}
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    {1'b0, 2'd2, 24'h001810, 32'h0,        1'b1, 4'b1111, 32'h18045AC3},
    {1'b0, 2'd0, 24'h001812, 32'h0,        1'b1, 4'b0100, 32'h00000004},
    {1'b0, 2'd1, 24'h001812, 32'h0,        1'b1, 4'b1100, 32'h00001804},
    {1'b0, 2'd0, 24'h001811, 32'h0,        1'b1, 4'b0010, 32'h0000005A},
    {1'b0, 2'd2, 24'h000310, 32'h0,        1'b1, 4'b1111, 32'h03045AC3},
    {1'b0, 2'd2, 24'h002040, 32'h0,        1'b0, 4'b0000, 32'hFFFFFFFF},
    {1'b0, 2'd0, 24'h002041, 32'h0,        1'b0, 4'b0000, 32'h000000FF},
    {1'b0, 2'd1, 24'h002042, 32'h0,        1'b0, 4'b0000, 32'h0000FFFF},
    {1'b0, 2'd2, 24'h012800, 32'h0,        1'b0, 4'b0000, 32'hFFFFFFFF},
    {1'b0, 2'd1, 24'h001813, 32'h0,        1'b0, 4'b0000, 32'h0000FFFF},
    {1'b0, 2'd2, 24'h001812, 32'h0,        1'b0, 4'b0000, 32'hFFFFFFFF},
    {1'b1, 2'd0, 24'h001821, 32'h123456AB, 1'b1, 4'b0010, 32'h0000AB00},
    {1'b1, 2'd1, 24'h000022, 32'hFFFF1234, 1'b1, 4'b1100, 32'h12340000},
    {1'b1, 2'd2, 24'h002040, 32'hDEADBEEF, 1'b0, 4'b0000, 32'h00000000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
    chk(dn_valid === 1'b0, "R10 dn_valid reset", {31'b0, dn_valid}, 32'h0);
    chk(rsp_valid === 1'b0, "R10 rsp_valid reset", {31'b0, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        w  = VEC[i][95];
      logic [1:0]  sz = VEC[i][94:93];
      logic [23:0] a  = VEC[i][92:69];
      logic [31:0] d  = VEC[i][68:37];
      logic        ed = VEC[i][36];
      logic [3:0]  eb = VEC[i][35:32];
      logic [31:0] ev = VEC[i][31:0];
      issue(w, sz, a, d);
      chk(c_dnv === ed, $sformatf("R2,R4,R6 vec %0d forward", i), {31'b0, c_dnv}, {31'b0, ed});
      chk(c_rsp_early === 1'b0, $sformatf("R10 vec %0d early rsp", i), {31'b0, c_rsp_early}, 32'h0);
      if (ed) begin
        chk(c_be === eb, $sformatf("R5 vec %0d byte enables", i), {28'b0, c_be}, {28'b0, eb});
        chk(c_devfn === a[15:8] && c_reg === a[7:2], $sformatf("R1 vec %0d fields", i),
            {18'b0, c_devfn, c_reg}, {18'b0, a[15:8], a[7:2]});
      end
      if (w) begin
        chk(c_rspv === 1'b0, $sformatf("R10 vec %0d write rsp", i), {31'b0, c_rspv}, 32'h0);
        if (ed) chk(c_wd === ev, $sformatf("R5 vec %0d write lanes", i), c_wd, ev);
      end else begin
        chk(c_rspv === 1'b1, $sformatf("R10 vec %0d read rsp", i), {31'b0, c_rspv}, 32'h1);
        chk(c_rspd === ev, $sformatf("R3,R5,R6 vec %0d read data", i), c_rspd, ev);
      end
    end

    // R6: width code 3 always misses.
    rd_expect(2'd3, 24'h001810, 32'hFFFFFFFF, "R6 width code 3");
    // R12: bridge 0 slot (seg0 dev1) reachable although not listed present.
    rd_expect(2'd2, 24'h000818, 32'h08065AC3, "R12 bridge slot read");
    // R7: unprogrammed bus misses.
    rd_expect(2'd2, 24'h052800, 32'hFFFFFFFF, "R7 bus5 before program");
    // R8: byte write at 0x19 of bridge 0.
    issue(1'b1, 2'd0, 24'h000819, 32'h00000005);
    chk(c_dnv === 1'b1, "R12 bridge write forwarded", {31'b0, c_dnv}, 32'h1);
    issue(1'b0, 2'd2, 24'h052800, 32'h0);
    chk(c_seg === 2'd1, "R8 bus5 to seg1", {30'b0, c_seg}, 32'h1);
    chk(c_rspd === 32'h28405AC3, "R8 bus5 read", c_rspd, 32'h28405AC3);
    // R9: byte write at 0x18 of bridge 1 is ignored.
    issue(1'b1, 2'd0, 24'h051018, 32'h00000900);
    rd_expect(2'd2, 24'h093800, 32'hFFFFFFFF, "R9 byte at 0x18 ignored");
    // R9: word write at 0x18 takes bits 15:8.
    issue(1'b1, 2'd1, 24'h051018, 32'h00000907);
    rd_expect(2'd2, 24'h093804, 32'h38815AC3, "R9 word at 0x18");
    // R11: bridge 1 copies bridge 0's number via dword write; bridge 0 wins.
    issue(1'b1, 2'd2, 24'h051018, 32'h00000500);
    rd_expect(2'd2, 24'h052800, 32'h28405AC3, "R11 lowest bridge wins");
    rd_expect(2'd2, 24'h093800, 32'hFFFFFFFF, "R9 old number released");
    // R7: clearing bridge 0 lets bridge 1 take bus 5.
    issue(1'b1, 2'd0, 24'h000819, 32'h00000000);
    rd_expect(2'd2, 24'h053800, 32'h38805AC3, "R7 zero matches nothing");
    rd_expect(2'd0, 24'h001813, 32'h00000018, "R2 root unaffected");
    // R7: reset clears learned numbers.
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_expect(2'd2, 24'h053800, 32'hFFFFFFFF, "R7 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule